// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

This block rearranges the bytes of a 32-bit operand and produces condition flags for the result. It has three swap operations: bytes exchanged inside each halfword, the four bytes of the word reversed, and the two halfwords exchanged. It also has four extension operations that sign- or zero-extend the low byte or the low halfword. For the swap operations the block produces zero, sign, carry and overflow flags. The carry flag here does not mean arithmetic carry. It reports that the result contains a zero byte or a zero halfword, and each swap operation checks at a different granularity.

Operand and operation enter on a valid/ready input stream. The result leaves through one register stage on a valid/ready output stream. The input is accepted on a clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value. Flag outputs should be written into a status register only when `out_flag_we` is high.

Top module: `swap_unit`

## Requirements
- R1: Operation code 0 (halfword byte swap) returns the operand with bytes 0 and 1 exchanged and bytes 2 and 3 exchanged.
- R2: Operation code 1 (word byte reversal) returns the operand with its four bytes in reverse order: byte 0 moves to byte 3, byte 1 to byte 2, and so on.
- R3: Operation code 2 (halfword swap) returns the operand with bits 31:16 and 15:0 exchanged.
- R4: For codes 0, 1 and 2, `out_flag_we` is 1, `out_ov` is 0, `out_z` is 1 exactly when the result is zero, and `out_s` equals result bit 31.
- R5: For code 1, `out_cy` is 1 when at least one of the four result bytes is zero.
- R6: For code 2, `out_cy` is 1 when result bits 15:0 are all zero or result bits 31:16 are all zero.
- R7: For code 0, `out_cy` is 1 when result byte 0 or result byte 1 is zero.
- R8: Code 3 sign-extends bits 7:0, code 4 zero-extends bits 7:0, code 5 sign-extends bits 15:0, and code 6 zero-extends bits 15:0.
- R9: For codes 3 to 7, `out_flag_we` is 0 and all four flag outputs are 0, so the stored flags are left unchanged.
- R10: Code 7 passes the operand through unchanged.
- R11: An accepted input appears with `out_valid` high on the next clock edge. While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold.
- R12: While `rst_n` is low and after reset is released, `out_valid` is 0 and `in_ready` is 1 until an input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and operation code are present |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_data | input | 32 | Operand |
| in_op | input | 3 | Operation code (0 to 7) |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Rearranged result |
| out_z | output | 1 | Zero flag |
| out_s | output | 1 | Sign flag |
| out_cy | output | 1 | Zero-byte or zero-halfword flag |
| out_ov | output | 1 | Overflow flag, always cleared |
| out_flag_we | output | 1 | Flags are to be written |

## Verification
Every operation code is applied to every operand whose bytes each come from 00, 01, 7F, 80 and FF. This set includes single zero bytes at every position, which separates the three carry granularities. It includes zero halfwords and an all-zero word, which exercise the zero flag, and bytes with the top bit set at every position, which exercise the sign flag and sign extension. Because the nonzero byte values differ from each other, any lane that is routed wrongly shows up in the result. A separate stall sequence holds `out_ready` low while a second input is waiting. It confirms that the first result stays intact and that the second result is accepted only on the edge where the first one drains.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [2:0] {
    OP_BSH  = 3'd0,
    OP_BSW  = 3'd1,
    OP_HSW  = 3'd2,
    OP_SXB  = 3'd3,
    OP_ZXB  = 3'd4,
    OP_SXH  = 3'd5,
    OP_ZXH  = 3'd6,
    OP_PASS = 3'd7
  } swap_op_e;

  typedef struct packed {
    logic ov;
    logic cy;
    logic s;
    logic z;
  } swap_flags_t;
endpackage

// File: rtl/swap_datapath.sv
module swap_datapath
  import swap_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [4*BYTE_W-1:0] din,
  input  swap_op_e            op,
  output logic [4*BYTE_W-1:0] res
);
  localparam int W     = 4 * BYTE_W;
  localparam int HALF  = 2 * BYTE_W;
  localparam int LANES = 4;

  logic [W-1:0] bsh, bsw, hsw;

  // Each swap is a lane permutation: target lane i takes source lane i XOR k.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bsh[i*BYTE_W +: BYTE_W] = din[(i ^ 1)*BYTE_W +: BYTE_W];
    assign hsw[i*BYTE_W +: BYTE_W] = din[(i ^ 2)*BYTE_W +: BYTE_W];
    assign bsw[i*BYTE_W +: BYTE_W] = din[(i ^ 3)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (op)
      OP_BSH:  res = bsh;
      OP_BSW:  res = bsw;
      OP_HSW:  res = hsw;
      OP_SXB:  res = {{(W-BYTE_W){din[BYTE_W-1]}}, din[BYTE_W-1:0]};
      OP_ZXB:  res = {{(W-BYTE_W){1'b0}}, din[BYTE_W-1:0]};
      OP_SXH:  res = {{(W-HALF){din[HALF-1]}}, din[HALF-1:0]};
      OP_ZXH:  res = {{(W-HALF){1'b0}}, din[HALF-1:0]};
      default: res = din;
    endcase
  end
endmodule

// File: rtl/swap_flags.sv
module swap_flags
  import swap_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [4*BYTE_W-1:0] res,
  input  swap_op_e            op,
  output swap_flags_t         flags,
  output logic                we
);
  localparam int W     = 4 * BYTE_W;
  localparam int LANES = 4;

  logic [LANES-1:0] lane_zero;

  for (genvar i = 0; i < LANES; i++) begin : g_zero
    assign lane_zero[i] = (res[i*BYTE_W +: BYTE_W] == '0);
  end

  logic cy_raw;

  always_comb begin
    unique case (op)
      OP_BSH:  cy_raw = lane_zero[0] | lane_zero[1];
      OP_BSW:  cy_raw = |lane_zero;
      OP_HSW:  cy_raw = (&lane_zero[1:0]) | (&lane_zero[3:2]);
      default: cy_raw = 1'b0;
    endcase
  end

  assign we = (op == OP_BSH) || (op == OP_BSW) || (op == OP_HSW);

  always_comb begin
    flags = '0;
    if (we) begin
      flags.z  = &lane_zero;
      flags.s  = res[W-1];
      flags.cy = cy_raw;
      flags.ov = 1'b0;
    end
  end
endmodule

// File: rtl/swap_stage.sv
module swap_stage
  import swap_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [W-1:0] in_res,
  input  swap_flags_t in_flags,
  input  logic        in_we,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [W-1:0] out_res,
  output swap_flags_t out_flags,
  output logic        out_we
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_flags <= '0;
      out_we    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res   <= in_res;
        out_flags <= in_flags;
        out_we    <= in_we;
      end
    end
  end
endmodule

// File: rtl/swap_unit.sv
module swap_unit
  import swap_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int W = 4 * BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic [2:0]   in_op,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_z,
  output logic         out_s,
  output logic         out_cy,
  output logic         out_ov,
  output logic         out_flag_we
);
  swap_op_e    op;
  logic [W-1:0] res;
  swap_flags_t  flags_c, flags_q;
  logic         we_c;

  assign op = swap_op_e'(in_op);

  swap_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .din (in_data),
    .op  (op),
    .res (res)
  );

  swap_flags #(.BYTE_W(BYTE_W)) u_fl (
    .res   (res),
    .op    (op),
    .flags (flags_c),
    .we    (we_c)
  );

  swap_stage #(.W(W)) u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (res),
    .in_flags  (flags_c),
    .in_we     (we_c),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (out_data),
    .out_flags (flags_q),
    .out_we    (out_flag_we)
  );

  assign out_z  = flags_q.z;
  assign out_s  = flags_q.s;
  assign out_cy = flags_q.cy;
  assign out_ov = flags_q.ov;
endmodule

// File: rtl/swap_unit_chk.sv
module swap_unit_chk #(
  parameter int BYTE_W = 8,
  localparam int W = 4 * BYTE_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic [2:0]   in_op,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_z,
  input logic         out_s,
  input logic         out_cy,
  input logic         out_ov,
  input logic         out_flag_we
);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_we |-> !out_ov);

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_we |-> out_z == (out_data == '0));

  // R4
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_we |-> out_s == out_data[W-1]);

  // R9
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_flag_we |-> !(out_z || out_s || out_cy || out_ov));

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_flag_we) && $stable(out_cy));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R12
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind swap_unit swap_unit_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_swap_unit.sv
module sim_swap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [2:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_z, out_s, out_cy, out_ov, out_flag_we;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  swap_unit u0 (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_op,
    .out_valid, .out_ready, .out_data,
    .out_z, .out_s, .out_cy, .out_ov, .out_flag_we
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [2:0] op, logic [31:0] d);
    case (op)
      3'd0: return ((d & 32'h00FF00FF) << 8) | ((d >> 8) & 32'h00FF00FF);
      3'd1: return {d[7:0], d[15:8], d[23:16], d[31:24]};
      3'd2: return (d << 16) | (d >> 16);
      3'd3: return 32'(signed'(d[7:0]));
      3'd4: return d & 32'hFF;
      3'd5: return 32'(signed'(d[15:0]));
      3'd6: return d & 32'hFFFF;
      default: return d;
    endcase
  endfunction

  function automatic string data_tag(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd7: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic run_one(logic [2:0] op, logic [31:0] d);
    logic [31:0] r;
    logic        swp, cy;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = d; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r   = model(op, d);
    swp = (op <= 3'd2);
    cy  = 1'b0;
    if (op == 3'd0) cy = (r[7:0] == 0) || (r[15:8] == 0);           // R7
    if (op == 3'd1) cy = (r[7:0] == 0) || (r[15:8] == 0)
                      || (r[23:16] == 0) || (r[31:24] == 0);        // R5
    if (op == 3'd2) cy = (r[15:0] == 0) || (r[31:16] == 0);         // R6
    check("R11", 32'(out_valid), 32'd1, "out_valid after accept");
    check(data_tag(op), out_data, r, "result");
    if (swp) begin
      check("R4", {28'd0, out_flag_we, out_ov, out_s, out_z},
            {28'd0, 1'b1, 1'b0, r[31], r == 0}, "we/ov/s/z");
      check(op == 0 ? "R7" : (op == 1 ? "R5" : "R6"), 32'(out_cy), 32'(cy), "carry");
    end else begin
      check("R9", {27'd0, out_flag_we, out_ov, out_cy, out_s, out_z}, 32'd0, "flags quiet");
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [5];
    vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h7F; vals[3] = 8'h80; vals[4] = 8'hFF;

    // R12: reset state
    #12;
    check("R12", {30'd0, out_valid, in_ready}, 32'b01, "in reset valid/ready");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R12", {30'd0, out_valid, in_ready}, 32'b01, "after reset valid/ready");

    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++)
          for (int c = 0; c < 5; c++)
            for (int e = 0; e < 5; e++)
              run_one(3'(op), {vals[a], vals[b], vals[c], vals[e]});

    // R11: back-pressure sequence
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_op = 3'd1; in_data = 32'h11223344;
    @(negedge clk);
    in_data = 32'hA0B0C0D0; in_op = 3'd2;
    check("R11", {30'd0, out_valid, in_ready}, 32'b10, "stalled valid/ready");
    check("R11", out_data, 32'h44332211, "first result");
    repeat (3) @(negedge clk);
    check("R11", out_data, 32'h44332211, "held during stall");
    check("R11", 32'(in_ready), 32'd0, "ready low during stall");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", {31'd0, out_valid}, 32'd1, "second valid");
    check("R3", out_data, 32'hC0D0A0B0, "second result after drain");
    @(negedge clk);
    check("R11", {30'd0, out_valid, in_ready}, 32'b01, "drained");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule